// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block sits beside a byte-wide memory with a 128K-byte space. It watches every completed bus access and keeps an 8-bit protection register with one bit per 16K-byte sector. Any write aimed at a sector whose bit is set is flagged with a combinational write-inhibit output, so the array controller can drop it. The protection value can only change through a fixed unlock handshake. The handshake is six reads from set addresses in a set order. These are followed by a write that carries the new protection byte and a second write that carries its bitwise complement. Any deviation silently abandons the attempt.

Each access is presented for one clock as a single-cycle `acc_valid` pulse, together with its direction, address and write data. The unlock reads stay ordinary reads. The sequencer only observes them. The two protection writes are always inhibited, so they never reach the array, and their address is not used. The stored setting stands in for nonvolatile storage and is cleared by reset.

States: `ST_IDLE` (waiting), `ST_LEAD` (a 00000h read was seen), `ST_R1`..`ST_R6` (that many unlock reads matched), `ST_CONF` (pending byte captured, complement awaited). Transitions: *start* (IDLE→R1 on 05555h after a select gap), *lead* (IDLE/LEAD→LEAD on 00000h), *lead-start* (LEAD→R1 on 05555h), *advance* (Rk→Rk+1 on the next address), *capture* (R6→CONF on a write), *commit*/*drop* (CONF→IDLE on a matching or mismatching complement), *abort* (any wrong access→IDLE, or →R1 on 05555h, or →LEAD on 00000h).

Top module: `wp_unlock_seq`

## Requirements
- R1: Address bits [16:14] select the sector, and bit n of `prot_q` guards sector n. When a valid write hits a sector whose bit is 1, `wr_inhibit` is 1 in that cycle. A valid write to a sector whose bit is 0 leaves it at 0 when the sequencer is not consuming a protection write.
- R2: `wr_inhibit` is 0 for every read and in every cycle without `acc_valid`.
- R3: After reset, `prot_q` is 8'h00 and the sequencer is idle.
- R4: Unlock requires six valid reads, in this order: 05555h, 1AAAAh, 03333h, 1CCCCh, 100FFh, 0FF00h. From idle, 05555h starts the sequence only if `chip_sel` was low in some cycle since the previous access. Otherwise a read of 00000h must come first.
- R5: A read with the wrong address aborts the sequence. If that read is 05555h, it counts as the first unlock read. If it is 00000h, it counts as the lead read.
- R6: The first access after the sixth read must be a write. Its data is held as the pending value. A read at that point aborts, so a seventh read leaves `prot_q` unchanged.
- R7: The access after the pending write must be a write whose data equals the bitwise complement of the pending value. Then `prot_q` takes the pending value on the next clock edge. Any other data leaves `prot_q` unchanged and returns the sequencer to idle.
- R8: Both protection writes raise `wr_inhibit`, whatever their address and whatever the protection bits.
- R9: A write arriving while the six reads are still in progress aborts the sequence.
- R10: Inputs are ignored unless `acc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| acc_valid | input | 1 | One-cycle pulse marking a completed access |
| acc_write | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address of the access |
| wdata | input | 8 | Write data |
| prot_q | output | 8 | Protection register, bit n guards sector n |
| wr_inhibit | output | 1 | Block the current write |

## Verification
On every cycle the assertions check these rules: reads are never inhibited, a protected sector always inhibits, the protection register only changes right after a write in the confirm state, and the confirm state is only entered by a write. Other behaviour only shows up over whole scenarios, and the bench drives those: the exact address order, the select-gap rule against the lead read, restarting on a stray 05555h, the seventh-read abort, a wrong complement, and the fact that a captured byte never takes effect without its complement.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int ADDR_W    = 17;
    localparam int DATA_W    = 8;
    localparam int SECT_BITS = 3;
    localparam int STEPS     = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_R1,
        ST_R2,
        ST_R3,
        ST_R4,
        ST_R5,
        ST_R6,
        ST_CONF
    } seq_state_t;

    // Unlock address expected at step k (0-based)
    function automatic logic [ADDR_W-1:0] step_addr(input int k);
        case (k)
            0:       step_addr = 17'h05555;
            1:       step_addr = 17'h1AAAA;
            2:       step_addr = 17'h03333;
            3:       step_addr = 17'h1CCCC;
            4:       step_addr = 17'h100FF;
            default: step_addr = 17'h0FF00;
        endcase
    endfunction
endpackage

// File: rtl/wp_addr_match.sv
module wp_addr_match
    import wp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = STEPS
) (
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] hit,
    output logic          hit_zero
);
    for (genvar i = 0; i < NS; i++) begin : g_cmp
        assign hit[i] = (addr == step_addr(i));
    end
    assign hit_zero = (addr == '0);
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
    import wp_pkg::*;
#(
    parameter int NS = STEPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [NS-1:0] hit,
    input  logic          hit_zero,
    input  logic          cmp_ok,
    output seq_state_t    state,
    output logic          cap_pend,
    output logic          commit,
    output logic          consume
);
    seq_state_t nxt;
    logic       sel_gap;

    // Restart target when a sequence read mismatches
    function automatic seq_state_t abort_to(input logic h0, input logic hz);
        if (h0)      abort_to = ST_R1;
        else if (hz) abort_to = ST_LEAD;
        else         abort_to = ST_IDLE;
    endfunction

    function automatic seq_state_t step_after(input seq_state_t s);
        case (s)
            ST_R1:   step_after = ST_R2;
            ST_R2:   step_after = ST_R3;
            ST_R3:   step_after = ST_R4;
            ST_R4:   step_after = ST_R5;
            default: step_after = ST_R6;
        endcase
    endfunction

    function automatic int step_idx(input seq_state_t s);
        case (s)
            ST_R1:   step_idx = 1;
            ST_R2:   step_idx = 2;
            ST_R3:   step_idx = 3;
            ST_R4:   step_idx = 4;
            default: step_idx = 5;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_gap <= 1'b1;
        end else begin
            state <= nxt;
            if (acc_valid)      sel_gap <= 1'b0;
            else if (!chip_sel) sel_gap <= 1'b1;
        end
    end

    always_comb begin
        nxt      = state;
        cap_pend = 1'b0;
        commit   = 1'b0;
        consume  = (state == ST_R6) || (state == ST_CONF);
        if (acc_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (acc_write)                nxt = ST_IDLE;
                    else if (hit[0] && sel_gap)   nxt = ST_R1;
                    else if (hit_zero)            nxt = ST_LEAD;
                    else                          nxt = ST_IDLE;
                end
                ST_LEAD: begin
                    if (acc_write) nxt = ST_IDLE;
                    else           nxt = abort_to(hit[0], hit_zero);
                end
                ST_R1, ST_R2, ST_R3, ST_R4, ST_R5: begin
                    if (acc_write)                 nxt = ST_IDLE;
                    else if (hit[step_idx(state)]) nxt = step_after(state);
                    else                           nxt = abort_to(hit[0], hit_zero);
                end
                ST_R6: begin
                    if (acc_write) begin
                        nxt      = ST_CONF;
                        cap_pend = 1'b1;
                    end else begin
                        nxt = abort_to(hit[0], hit_zero);
                    end
                end
                ST_CONF: begin
                    if (acc_write) begin
                        nxt    = ST_IDLE;
                        commit = cmp_ok;
                    end else begin
                        nxt = abort_to(hit[0], hit_zero);
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // R6: confirm state is only entered by a write
    a_r6_conf_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONF && $past(state) != ST_CONF) |-> $past(acc_valid && acc_write));

    // R4: first unlock step is only reached by a read
    a_r4_r1_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R1 && $past(state) != ST_R1) |-> $past(acc_valid && !acc_write));

    // R10: no state movement without a valid access
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> $stable(state));
endmodule

// File: rtl/wp_prot_store.sv
module wp_prot_store
    import wp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wdata,
    input  logic          cap_pend,
    input  logic          commit,
    input  seq_state_t    state,
    input  logic          acc_valid,
    input  logic          acc_write,
    output logic          cmp_ok,
    output logic [DW-1:0] prot_q
);
    logic [DW-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            prot_q <= '0;
        end else begin
            if (cap_pend) pend_q <= wdata;
            if (commit)   prot_q <= pend_q;
        end
    end

    assign cmp_ok = (wdata == ~pend_q);

    // R7: protection only changes right after a write in the confirm state
    a_r7_change_after_conf: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q != $past(prot_q)) |-> $past(state == ST_CONF && acc_valid && acc_write));
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
    import wp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SB = SECT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] prot_q,
    output logic          wr_inhibit
);
    localparam int SECT_LO = AW - SB;

    logic [STEPS-1:0] hit;
    logic             hit_zero, cmp_ok, cap_pend, commit, consume;
    seq_state_t       state;
    logic [SB-1:0]    sect;

    wp_addr_match #(.AW(AW), .NS(STEPS)) u_match (
        .addr(addr), .hit(hit), .hit_zero(hit_zero)
    );

    wp_seq_fsm #(.NS(STEPS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .hit(hit), .hit_zero(hit_zero), .cmp_ok(cmp_ok),
        .state(state), .cap_pend(cap_pend), .commit(commit), .consume(consume)
    );

    wp_prot_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wdata(wdata),
        .cap_pend(cap_pend), .commit(commit), .state(state),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .cmp_ok(cmp_ok), .prot_q(prot_q)
    );

    assign sect       = addr[AW-1:SECT_LO];
    assign wr_inhibit = acc_valid && acc_write && (prot_q[sect] || consume);

    // R2: reads are never blocked
    a_r2_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |-> !wr_inhibit);

    // R1: a write into a guarded sector is always blocked
    a_r1_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && prot_q[addr[AW-1:SECT_LO]]) |-> wr_inhibit);
endmodule

// File: tb/wp_unlock_seq_test.sv
module wp_unlock_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  prot_q;
    logic        wr_inhibit;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_unlock_seq uut (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .acc_valid(acc_valid),
        .acc_write(acc_write), .addr(addr), .wdata(wdata),
        .prot_q(prot_q), .wr_inhibit(wr_inhibit)
    );

    // {write, gap, addr, data, exp_inhibit, exp_prot_after}
    localparam logic [35:0] VEC [NV] = '{
        {1'b0,1'b1,17'h05555,8'h00,1'b0,8'h00},
        {1'b0,1'b1,17'h1AAAA,8'h00,1'b0,8'h00},
        {1'b0,1'b1,17'h03333,8'h00,1'b0,8'h00},
        {1'b0,1'b1,17'h1CCCC,8'h00,1'b0,8'h00},
        {1'b0,1'b1,17'h100FF,8'h00,1'b0,8'h00},
        {1'b0,1'b1,17'h0FF00,8'h00,1'b0,8'h00},
        {1'b1,1'b1,17'h00000,8'hA5,1'b1,8'h00},
        {1'b1,1'b1,17'h1FFFF,8'h5A,1'b1,8'hA5},
        {1'b1,1'b1,17'h00000,8'h11,1'b1,8'hA5},
        {1'b1,1'b1,17'h04000,8'h22,1'b0,8'hA5},
        {1'b1,1'b1,17'h1C000,8'h33,1'b1,8'hA5},
        {1'b0,1'b1,17'h05555,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1AAAA,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h03333,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1CCCC,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h100FF,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h0FF00,8'h00,1'b0,8'hA5},
        {1'b1,1'b1,17'h08000,8'h0F,1'b1,8'hA5},
        {1'b1,1'b1,17'h08000,8'hF1,1'b1,8'hA5},
        {1'b1,1'b1,17'h04000,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h05555,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1AAAA,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h03333,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1CCCC,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h100FF,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h0FF00,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1AAAA,8'h00,1'b0,8'hA5},
        {1'b1,1'b1,17'h04000,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h05555,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h03333,8'h00,1'b0,8'hA5},
        {1'b1,1'b1,17'h14000,8'h00,1'b1,8'hA5},
        {1'b0,1'b1,17'h05555,8'h00,1'b0,8'hA5},
        {1'b0,1'b1,17'h1AAAA,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h05555,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h1AAAA,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h03333,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h1CCCC,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h100FF,8'h00,1'b0,8'hA5},
        {1'b0,1'b0,17'h0FF00,8'h00,1'b0,8'hA5},
        {1'b1,1'b0,17'h00000,8'h00,1'b1,8'hA5},
        {1'b1,1'b0,17'h00000,8'hFF,1'b1,8'h00},
        {1'b1,1'b0,17'h1C000,8'h00,1'b0,8'h00}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One idle cycle (select low when gap) then one access cycle.
    task automatic access(input logic w, input logic gap, input logic [16:0] a,
                          input logic [7:0] d, input logic exp_inh,
                          input logic [7:0] exp_prot, input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        chip_sel  = gap ? 1'b0 : 1'b1;
        @(negedge clk);
        chip_sel  = 1'b1;
        acc_valid = 1'b1;
        acc_write = w;
        addr      = a;
        wdata     = d;
        #1;
        check(req, "wr_inhibit", int'(wr_inhibit), int'(exp_inh));
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, "prot_q", int'(prot_q), int'(exp_prot));
    endtask

    task automatic unlock_reads(input logic gap, input logic [7:0] p);
        access(1'b0, gap, 17'h05555, 8'h00, 1'b0, p, "R4");
        access(1'b0, gap, 17'h1AAAA, 8'h00, 1'b0, p, "R4");
        access(1'b0, gap, 17'h03333, 8'h00, 1'b0, p, "R4");
        access(1'b0, gap, 17'h1CCCC, 8'h00, 1'b0, p, "R4");
        access(1'b0, gap, 17'h100FF, 8'h00, 1'b0, p, "R4");
        access(1'b0, gap, 17'h0FF00, 8'h00, 1'b0, p, "R4");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3", "prot_q after reset", int'(prot_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", "prot_q idle", int'(prot_q), 0);

        // Table: R1 R2 R4 R5 R6 R7 R8 R9 scenarios
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][35], VEC[i][34], VEC[i][33:17], VEC[i][16:9],
                   VEC[i][8], VEC[i][7:0], "R1/R5/R6/R7/R8 table");
        end

        // R4: select held, 05555h from idle does not start; capture write passes
        unlock_reads(1'b0, 8'h00);
        access(1'b1, 1'b0, 17'h04000, 8'h44, 1'b0, 8'h00, "R4 no gap");
        access(1'b1, 1'b0, 17'h04000, 8'hBB, 1'b0, 8'h00, "R4 no gap");

        // R4/R5: lead read of 00000h with select held enables the sequence
        access(1'b0, 1'b0, 17'h00000, 8'h00, 1'b0, 8'h00, "R5 lead");
        unlock_reads(1'b0, 8'h00);
        access(1'b1, 1'b0, 17'h0C000, 8'h81, 1'b1, 8'h00, "R8 capture");
        access(1'b1, 1'b0, 17'h0C000, 8'h7E, 1'b1, 8'h81, "R7 commit");

        // R9: a write in mid sequence aborts
        access(1'b0, 1'b1, 17'h05555, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b0, 1'b1, 17'h1AAAA, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b1, 1'b1, 17'h04000, 8'h00, 1'b0, 8'h81, "R9 write aborts");
        access(1'b0, 1'b1, 17'h03333, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b0, 1'b1, 17'h1CCCC, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b0, 1'b1, 17'h100FF, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b0, 1'b1, 17'h0FF00, 8'h00, 1'b0, 8'h81, "R9");
        access(1'b1, 1'b1, 17'h04000, 8'h00, 1'b0, 8'h81, "R9 not consumed");

        // R10 and R2: activity without acc_valid is ignored
        @(negedge clk);
        acc_write = 1'b1; addr = 17'h1C000; wdata = 8'h00; chip_sel = 1'b1;
        #1;
        check("R2", "wr_inhibit without valid", int'(wr_inhibit), 0);
        repeat (4) @(negedge clk);
        check("R10", "prot_q without valid", int'(prot_q), 8'h81);
        access(1'b1, 1'b1, 17'h1C000, 8'h00, 1'b1, 8'h81, "R1 sector7");

        // R3: reset clears a committed setting
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3", "prot_q after second reset", int'(prot_q), 0);
        rst_n = 1'b1;
        access(1'b1, 1'b1, 17'h1C000, 8'h00, 1'b0, 8'h00, "R3 unguarded");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule